// File: doc/BRIEF.md
# Multi-mode TDM audio input deserializer

This block receives time-division-multiplexed audio on up to three serial data lanes. It runs directly on the incoming bit clock, so it operates as a slave to both the bit clock and the frame clock. Each channel occupies a 32-bit slot. A frame-density selector chooses 512, 256 or 128 bit clocks per frame. That choice also sets how the twelve 24-bit two's-complement channels are spread over the lanes:

- 512: all twelve channels on lane 0.
- 256: eight channels on lane 0 and four on lane 1.
- 128: four channels on each of the three lanes.

A format selector places the sample inside its slot. The options are left-aligned, left-aligned with a one-bit delay, or right-aligned with 16, 20 or 24 significant bits.

The block recovers every channel of a frame into a working store. When the last bit of the frame has been sampled, it copies the whole store to the parallel output in one step and pulses a valid strobe. It expects the next frame clock rising edge exactly one frame length after the previous one. If the edge comes early or is missing, the block raises an error pulse, discards the frame and waits for a fresh edge.

The control is a three-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Hunting for a frame edge. The mode inputs are sampled here. |
| `ST_RUN` | Receiving bits 1 to N-1 of a frame. |
| `ST_SYNC` | The cycle in which the next frame edge must be seen. |

Its transitions are:

| Transition | From → To | Condition |
|---|---|---|
| *start* | `ST_IDLE` → `ST_RUN` | A rising edge is seen. |
| *advance* | `ST_RUN` → `ST_RUN` | Any bit other than the last. |
| *frame end* | `ST_RUN` → `ST_SYNC` | The last bit has been sampled. |
| *early edge* | `ST_RUN` → `ST_IDLE` | An edge arrives in `ST_RUN`. The error is raised. |
| *chain* | `ST_SYNC` → `ST_RUN` | The edge arrives on time. |
| *missing edge* | `ST_SYNC` → `ST_IDLE` | No edge in `ST_SYNC`. The error is raised. |

Top module: `tdm_rx`

## Requirements
- R1: While `rst_n` is low and after its release, before the first frame completes, `ch_data` is all zero and `frame_valid` and `frame_err` are low.
- R2: Lanes are sampled on the rising edge of `bck`, MSB first, in 32-bit slots; channel c (0=L1, 1=R1, 2=L2 … 11=R6) appears at `ch_data[24c+23:24c]`. With `dens_sel`=0 (512 bits per frame) channel s comes from slot s of lane 0 for s=0..11; slots 12..15 and lanes 1 and 2 are ignored.
- R3: With `dens_sel`=1 (256 bits) lane 0 slots 0..7 carry channels 0..7, lane 1 slots 0..3 carry channels 8..11, and lane 2 is ignored.
- R4: With `dens_sel`=2 (128 bits) lane l slot s (s=0..3) carries channel 4l+s on each of the three lanes.
- R5: `fmt_sel` places the sample inside the slot (bit 0 = first slot bit): 3 = left-aligned 24-bit in bits 0..23, 4 = one-bit-delayed 24-bit in bits 1..24, 2 = right-aligned 24-bit in bits 8..31. Bits outside the window are ignored.
- R6: `fmt_sel`=0 (right-aligned 16-bit, bits 16..31) and `fmt_sel`=1 (right-aligned 20-bit, bits 12..31) give outputs sign-extended to 24 bits.
- R7: A frame begins on the bit where `fclk` is sampled high after being sampled low. The cycle after the last bit of the frame is sampled, `frame_valid` is high for exactly one cycle and every channel updates at once. `ch_data` holds at all other times.
- R8: If a frame edge arrives before the full frame length, `frame_err` pulses for one cycle in the cycle after that edge is sampled. That frame and the one the edge starts give no `frame_valid`, and reception resumes at the following edge.
- R9: If no edge is sampled in the bit right after a frame ends, `frame_err` pulses for one cycle after that bit. The block then waits for the next edge and resumes correct reception from it.
- R10: `dens_sel` and `fmt_sel` are taken only while the block waits for a frame edge (after reset or an error); changes while frames are received have no effect on the output.
- R11: `dens_sel`=3 acts as 2 (128 bits per frame), and `fmt_sel` values 5 to 7 act as 3 (left-aligned 24-bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck | input | 1 | Bit clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fclk | input | 1 | Frame clock; a rising edge starts a frame |
| sd_in | input | 3 | Serial data lanes 0..2 |
| dens_sel | input | 2 | Frame density: 0=512, 1=256, 2/3=128 bit clocks |
| fmt_sel | input | 3 | Slot format: 0 RJ16, 1 RJ20, 2 RJ24, 3 LJ24, 4 delayed LJ24, 5..7 as 3 |
| ch_data | output | 288 | Twelve 24-bit channels, channel c at bits 24c+23:24c |
| frame_valid | output | 1 | One-cycle pulse when a whole frame has been delivered |
| frame_err | output | 1 | One-cycle pulse on an early or missing frame edge |

## Verification
The bench builds the block with its default constants: 24-bit samples in 32-bit slots, three lanes and twelve channels. With these, even the longest frame is only 512 bit clocks, so the bench can sweep every density code against every format code frame by frame. It also runs the two reserved density and format codes, a shortened frame and a stretched frame. The expected lane bits and channel values are generated arithmetically from a channel and frame number, with non-window slot bits and unused lanes filled with junk that must not leak into any output.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    parameter int SAMP_W    = 24;
    parameter int SLOT_W    = 32;
    parameter int NLANE     = 3;
    parameter int NCH       = 12;
    parameter int MAX_SLOTS = 16;
    parameter int RJ_NARROW = 16;
    parameter int RJ_MID    = 20;

    localparam int POS_W   = $clog2(SLOT_W);
    localparam int CNT_W   = $clog2(MAX_SLOTS * SLOT_W) + 1;
    localparam int SLOT_IW = CNT_W - POS_W;
    localparam int LEN_W   = $clog2(SAMP_W) + 1;

    typedef enum logic [1:0] {
        DENS_512 = 2'd0,
        DENS_256 = 2'd1,
        DENS_128 = 2'd2
    } dens_e;

    typedef enum logic [2:0] {
        FMT_RJ16 = 3'd0,
        FMT_RJ20 = 3'd1,
        FMT_RJ24 = 3'd2,
        FMT_LJ24 = 3'd3,
        FMT_DL24 = 3'd4
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SYNC = 2'd2
    } st_e;

    function automatic dens_e norm_dens(input logic [1:0] v);
        return (v == 2'd3) ? DENS_128 : dens_e'(v);
    endfunction

    function automatic fmt_e norm_fmt(input logic [2:0] v);
        return (v > 3'd4) ? FMT_LJ24 : fmt_e'(v);
    endfunction

    function automatic logic [CNT_W-1:0] frame_bits(input dens_e d);
        logic [CNT_W-1:0] full;
        full = CNT_W'(MAX_SLOTS * SLOT_W);
        case (d)
            DENS_512: return full;
            DENS_256: return full >> 1;
            default:  return full >> 2;
        endcase
    endfunction

    function automatic int lane_chans(input dens_e d, input int lane);
        case (d)
            DENS_512: return (lane == 0) ? NCH : 0;
            DENS_256: return (lane == 0) ? (NCH * 2) / 3 :
                             (lane == 1) ? NCH / 3 : 0;
            default:  return NCH / NLANE;
        endcase
    endfunction

    function automatic int lane_base(input dens_e d, input int lane);
        case (d)
            DENS_512: return 0;
            DENS_256: return (lane == 1) ? (NCH * 2) / 3 : 0;
            default:  return lane * (NCH / NLANE);
        endcase
    endfunction

    function automatic logic [POS_W-1:0] win_off(input fmt_e f);
        case (f)
            FMT_RJ16: return POS_W'(SLOT_W - RJ_NARROW);
            FMT_RJ20: return POS_W'(SLOT_W - RJ_MID);
            FMT_RJ24: return POS_W'(SLOT_W - SAMP_W);
            FMT_DL24: return POS_W'(1);
            default:  return '0;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] win_len(input fmt_e f);
        case (f)
            FMT_RJ16: return LEN_W'(RJ_NARROW);
            FMT_RJ20: return LEN_W'(RJ_MID);
            default:  return LEN_W'(SAMP_W);
        endcase
    endfunction

endpackage

// File: rtl/tdm_lane_shift.sv
module tdm_lane_shift
    import tdm_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [POS_W-1:0]  pos,
    input  logic              bit_in,
    input  logic [POS_W-1:0]  off,
    input  logic [LEN_W-1:0]  len,
    output logic              cap,
    output logic [SAMP_W-1:0] sample
);

    localparam int EW = LEN_W + 1;

    logic [SAMP_W-1:0] sh_q;
    logic [SAMP_W-1:0] sh_n;
    logic [EW-1:0]     pos_e;
    logic [EW-1:0]     off_e;
    logic              in_win;
    logic              sgn;

    always_comb begin
        pos_e  = EW'(pos);
        off_e  = EW'(off);
        in_win = en && (pos_e >= off_e) && ((pos_e - off_e) < EW'(len));
        if (!in_win)
            sh_n = sh_q;
        else if (pos == off)
            sh_n = SAMP_W'(bit_in);
        else
            sh_n = {sh_q[SAMP_W-2:0], bit_in};
    end

    always_comb begin
        sgn = sh_n[0];
        for (int i = 0; i < SAMP_W; i++)
            if (LEN_W'(i + 1) == len)
                sgn = sh_n[i];
        for (int i = 0; i < SAMP_W; i++)
            sample[i] = (LEN_W'(i) < len) ? sh_n[i] : sgn;
    end

    assign cap = en && (pos == POS_W'(SLOT_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= sh_n;
    end

endmodule

// File: rtl/tdm_frame_fsm.sv
module tdm_frame_fsm
    import tdm_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fclk,
    input  logic [1:0]         dens_sel,
    input  logic [2:0]         fmt_sel,
    output logic               proc_en,
    output logic [POS_W-1:0]   pos,
    output logic [SLOT_IW-1:0] slot,
    output logic               last_bit,
    output logic               err_det,
    output dens_e              dens_act,
    output fmt_e               fmt_act
);

    st_e              st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] flen;
    logic             fclk_q;
    logic             rise;
    dens_e            dens_q, dens_now;
    fmt_e             fmt_q, fmt_now;

    assign rise     = fclk && !fclk_q;
    assign dens_now = norm_dens(dens_sel);
    assign fmt_now  = norm_fmt(fmt_sel);
    assign dens_act = (st_q == ST_IDLE) ? dens_now : dens_q;
    assign fmt_act  = (st_q == ST_IDLE) ? fmt_now  : fmt_q;
    assign flen     = frame_bits(dens_act);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            fclk_q <= 1'b1;
            dens_q <= DENS_512;
            fmt_q  <= FMT_RJ16;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            fclk_q <= fclk;
            if (st_q == ST_IDLE) begin
                dens_q <= dens_now;
                fmt_q  <= fmt_now;
            end
        end
    end

    // next state
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (rise) begin            // start
                    st_n  = ST_RUN;
                    cnt_n = CNT_W'(1);
                end
            end
            ST_RUN: begin
                if (rise) begin            // early edge
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end else if (cnt_q == flen - CNT_W'(1)) begin  // frame end
                    st_n  = ST_SYNC;
                    cnt_n = '0;
                end else begin             // advance
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            ST_SYNC: begin
                if (rise) begin            // chain
                    st_n  = ST_RUN;
                    cnt_n = CNT_W'(1);
                end else begin             // missing edge
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end
            end
            default: begin
                st_n  = ST_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        idx      = (st_q == ST_RUN) ? cnt_q : '0;
        pos      = idx[POS_W-1:0];
        slot     = idx[CNT_W-1:POS_W];
        proc_en  = 1'b0;
        last_bit = 1'b0;
        err_det  = 1'b0;
        unique case (st_q)
            ST_IDLE: proc_en = rise;
            ST_RUN: begin
                proc_en  = !rise;
                last_bit = !rise && (cnt_q == flen - CNT_W'(1));
                err_det  = rise;
            end
            ST_SYNC: begin
                proc_en = rise;
                err_det = !rise;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
    import tdm_rx_pkg::*;
(
    input  logic                    bck,
    input  logic                    rst_n,
    input  logic                    fclk,
    input  logic [NLANE-1:0]        sd_in,
    input  logic [1:0]              dens_sel,
    input  logic [2:0]              fmt_sel,
    output logic [NCH*SAMP_W-1:0]   ch_data,
    output logic                    frame_valid,
    output logic                    frame_err
);

    logic               proc_en;
    logic [POS_W-1:0]   pos;
    logic [SLOT_IW-1:0] slot;
    logic               last_bit;
    logic               err_det;
    dens_e              dens_act;
    fmt_e               fmt_act;

    logic [NLANE-1:0]   lane_cap;
    logic [SAMP_W-1:0]  lane_samp [NLANE];
    logic [SAMP_W-1:0]  ch_work_q [NCH];
    logic [SAMP_W-1:0]  ch_work_n [NCH];
    logic [SAMP_W-1:0]  ch_out_q  [NCH];
    logic               valid_q;
    logic               err_q;

    tdm_frame_fsm u_fsm (
        .clk      (bck),
        .rst_n    (rst_n),
        .fclk     (fclk),
        .dens_sel (dens_sel),
        .fmt_sel  (fmt_sel),
        .proc_en  (proc_en),
        .pos      (pos),
        .slot     (slot),
        .last_bit (last_bit),
        .err_det  (err_det),
        .dens_act (dens_act),
        .fmt_act  (fmt_act)
    );

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        tdm_lane_shift u_shift (
            .clk    (bck),
            .rst_n  (rst_n),
            .en     (proc_en),
            .pos    (pos),
            .bit_in (sd_in[l]),
            .off    (win_off(fmt_act)),
            .len    (win_len(fmt_act)),
            .cap    (lane_cap[l]),
            .sample (lane_samp[l])
        );
    end

    // route completed slots into the working store
    always_comb begin
        for (int c = 0; c < NCH; c++)
            ch_work_n[c] = ch_work_q[c];
        for (int l = 0; l < NLANE; l++) begin
            if (lane_cap[l] && (int'(slot) < lane_chans(dens_act, l))) begin
                for (int c = 0; c < NCH; c++)
                    if (c == lane_base(dens_act, l) + int'(slot))
                        ch_work_n[c] = lane_samp[l];
            end
        end
    end

    always_ff @(posedge bck or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                ch_work_q[c] <= '0;
                ch_out_q[c]  <= '0;
            end
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                ch_work_q[c] <= ch_work_n[c];
                if (last_bit)
                    ch_out_q[c] <= ch_work_n[c];
            end
            valid_q <= last_bit;
            err_q   <= err_det;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_out
        assign ch_data[c*SAMP_W +: SAMP_W] = ch_out_q[c];
    end

    assign frame_valid = valid_q;
    assign frame_err   = err_q;

endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk
    import tdm_rx_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  frame_valid,
    input logic                  frame_err,
    input logic [NCH*SAMP_W-1:0] ch_data,
    input logic [1:0]            dens_act,
    input logic [2:0]            fmt_act
);

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable(ch_data));

    p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    p_err_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !frame_valid);

    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ($stable(dens_act) && $stable(fmt_act)));

endmodule

bind tdm_rx tdm_rx_chk u_chk (
    .clk         (bck),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_err   (frame_err),
    .ch_data     (ch_data),
    .dens_act    (dens_act),
    .fmt_act     (fmt_act)
);

// File: tb/tdm_rx_test.sv
module tdm_rx_test;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         fclk;
    logic [2:0]   sd;
    logic [1:0]   dens_sel;
    logic [2:0]   fmt_sel;
    logic [287:0] ch_data;
    logic         frame_valid;
    logic         frame_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tdm_rx uut (
        .bck         (clk),
        .rst_n       (rst_n),
        .fclk        (fclk),
        .sd_in       (sd),
        .dens_sel    (dens_sel),
        .fmt_sel     (fmt_sel),
        .ch_data     (ch_data),
        .frame_valid (frame_valid),
        .frame_err   (frame_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    function automatic logic [23:0] samp(input int c, input int f);
        return 24'((c + 1) * 32'h000B1D37) ^ 24'(f * 32'h005A3C96) ^ 24'h814201;
    endfunction

    function automatic int fl_of(input int d);
        return (d == 0) ? 512 : (d == 1) ? 256 : 128;
    endfunction

    function automatic int lane_ch(input int d, input int l, input int s);
        if (d == 0) return (l == 0 && s < 12) ? s : -1;
        if (d == 1) return (l == 0 && s < 8) ? s : (l == 1 && s < 4) ? 8 + s : -1;
        return (s < 4) ? 4 * l + s : -1;
    endfunction

    function automatic int off_of(input int f);
        return (f == 0) ? 16 : (f == 1) ? 12 : (f == 2) ? 8 : (f == 4) ? 1 : 0;
    endfunction

    function automatic int len_of(input int f);
        return (f == 0) ? 16 : (f == 1) ? 20 : 24;
    endfunction

    function automatic logic [23:0] exp_val(input int c, input int fno, input int f);
        logic [23:0] v;
        logic [23:0] r;
        int n;
        v = samp(c, fno);
        n = len_of(f);
        r = v;
        for (int i = 0; i < 24; i++)
            if (i >= n) r[i] = v[n-1];
        return r;
    endfunction

    function automatic logic bitval(input int d, input int f, input int l,
                                    input int k, input int fno);
        int s, p, c, o, n;
        logic [23:0] v;
        logic fill;
        s = k / 32;
        p = k % 32;
        c = lane_ch(d, l, s);
        fill = (((k * 7 + l * 3 + fno) % 5) < 2);
        if (c < 0) return fill;
        o = off_of(f);
        n = len_of(f);
        if (p >= o && p < o + n) begin
            v = samp(c, fno);
            return v[n - 1 - (p - o)];
        end
        return fill;
    endfunction

    task automatic reset_dut(input int d, input int f);
        @(negedge clk);
        rst_n    = 1'b0;
        fclk     = 1'b0;
        sd       = '0;
        dens_sel = 2'(d);
        fmt_sel  = 3'(f);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_frame(input int d, input int f, input int fno,
                              input int nbits, input int fhigh, input int err_at,
                              input bit exp_valid, input string tag, input int mut_at);
        int dn, fn;
        dn = (d == 3) ? 2 : d;
        fn = (f > 4) ? 3 : f;
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            if (k == 1) begin
                chk(frame_valid == 1'b0, "R7", {tag, " valid low after pulse"},
                    64'(frame_valid), 64'd0);
                if (err_at < 0)
                    chk(frame_err == 1'b0, "R8", {tag, " no error"}, 64'(frame_err), 64'd0);
            end
            if (err_at >= 0 && k == err_at + 1)
                chk(frame_err == 1'b1, "R8/R9", {tag, " error pulse"}, 64'(frame_err), 64'd1);
            if (k == mut_at) begin
                dens_sel = 2'((dn + 1) % 3);
                fmt_sel  = 3'((fn + 2) % 5);
            end
            fclk = (k < fhigh);
            for (int l = 0; l < 3; l++)
                sd[l] = bitval(dn, fn, l, k, fno);
        end
        @(posedge clk);
        #5;
        chk(frame_valid == exp_valid, "R7", {tag, " valid at frame end"},
            64'(frame_valid), 64'(exp_valid));
        if (exp_valid) begin
            for (int c = 0; c < 12; c++)
                chk(ch_data[c*24 +: 24] == exp_val(c, fno, fn), tag,
                    $sformatf("channel %0d frame %0d", c, fno),
                    64'(ch_data[c*24 +: 24]), 64'(exp_val(c, fno, fn)));
        end
    endtask

    initial begin
        string tag;
        rst_n    = 1'b0;
        fclk     = 1'b0;
        sd       = '0;
        dens_sel = '0;
        fmt_sel  = '0;
        repeat (3) @(negedge clk);
        chk(ch_data == '0, "R1", "reset data", 64'(ch_data[63:0]), 64'd0);
        chk(!frame_valid && !frame_err, "R1", "reset strobes",
            64'({frame_valid, frame_err}), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ch_data == '0 && !frame_valid, "R1", "idle after reset",
            64'(ch_data[63:0]), 64'd0);

        // every density against every format; second frame scrambles mode inputs
        for (int d = 0; d < 3; d++) begin
            for (int f = 0; f < 5; f++) begin
                tag = $sformatf("%s/%s d%0d f%0d",
                                (d == 0) ? "R2" : (d == 1) ? "R3" : "R4",
                                (f < 2) ? "R6" : "R5", d, f);
                reset_dut(d, f);
                send_frame(d, f, 2 * (d * 5 + f), fl_of(d), fl_of(d) / 2, -1, 1'b1, tag, -1);
                send_frame(d, f, 2 * (d * 5 + f) + 1, fl_of(d), fl_of(d) / 2, -1, 1'b1,
                           {"R10 ", tag}, 40);
            end
        end

        // reserved codes
        reset_dut(3, 7);
        send_frame(3, 7, 40, 128, 64, -1, 1'b1, "R11 dens3 fmt7", -1);
        reset_dut(3, 5);
        send_frame(3, 5, 41, 128, 64, -1, 1'b1, "R11 dens3 fmt5", -1);

        // early edge
        reset_dut(1, 2);
        send_frame(1, 2, 50, 256, 128, -1, 1'b1, "R8 good", -1);
        send_frame(1, 2, 99, 100, 50, -1, 1'b0, "R8 short", -1);
        send_frame(1, 2, 51, 256, 128, 0, 1'b0, "R8 discarded", -1);
        send_frame(1, 2, 52, 256, 128, -1, 1'b1, "R8 resync", -1);

        // missing edge
        reset_dut(2, 3);
        send_frame(2, 3, 60, 128, 64, -1, 1'b1, "R9 good", -1);
        send_frame(2, 3, 61, 256, 128, 128, 1'b0, "R9 stretched", -1);
        send_frame(2, 3, 62, 128, 64, -1, 1'b1, "R9 resync", -1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule